// File: doc/BRIEF.md
# Local Exclusive Reservation Monitor

This block tracks a single load-exclusive reservation for one core. It watches every memory operation the core issues (plain load, exclusive load, plain store, exclusive store), each presented for one cycle with an address and an access size. An exclusive load opens a reservation on a coarse region: the address with its low 11 bits masked off. The size of that load is kept with the region.

An exclusive store is judged against the reservation. It passes locally only when three things hold: a reservation is held, the store falls in the same region, and it uses the same size. One cycle after the store, the block raises a result strobe with the pass flag and the status code returned to the core. The code is 0 when the store may proceed and 1 when it fails.

A local pass is provisional. The store must still clear the system-wide check before memory is written, and this block performs no memory access itself. Every exclusive store ends the reservation, whether it passes or fails. A plain store by the same core into the reserved region also ends it.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation is held. An exclusive store then fails with status 1, even at address 0 with size 0.
- R2: An exclusive load followed by an exclusive store to the same address and size gives, one cycle after the store, resultValid=1, localPass=1 and statusCode=0.
- R3: Address bits [10:0] are ignored. A store whose address differs from the loaded one only in those bits is judged as matching.
- R4: An exclusive store whose address differs from the reservation in any bit above bit 10 fails (localPass=0, statusCode=1).
- R5: An exclusive store whose size differs from the reserved size fails. Sizes are encoded on opSize as none=0, byte=1, half-word=2, word=4.
- R6: Every exclusive store, passed or failed, ends the reservation. A following exclusive store with no new exclusive load fails.
- R7: A plain store into the reserved region ends the reservation. A plain store outside the region leaves it intact.
- R8: A plain load has no effect on the reservation.
- R9: resultValid is 1 exactly one cycle after an accepted exclusive store and 0 otherwise. When resultValid is 0, localPass and statusCode are 0. A cycle with opValid=0 is ignored. opKind is encoded as 0 plain load, 1 exclusive load, 2 plain store, 3 exclusive store.
- R10: A new exclusive load replaces any earlier reservation, both its region and its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 2 | Operation kind: 0 load, 1 exclusive load, 2 store, 3 exclusive store |
| opAddr | input | 32 | Byte address of the operation |
| opSize | input | 3 | Access size: 0 none, 1 byte, 2 half-word, 4 word |
| resultValid | output | 1 | Exclusive-store verdict is valid (one cycle after the store) |
| localPass | output | 1 | The store passed the local check |
| statusCode | output | 1 | Status for the core: 0 success, 1 failure |

## Verification
The internal state can only be seen through the verdict of the next exclusive store. A wrong state or tag register therefore shows as a wrong localPass/statusCode pair one cycle after that store, not when the fault occurs. For that reason the stimulus places an exclusive store right after each event that should keep or drop a reservation. Those events are plain loads, plain stores inside and outside the region, reloads and earlier stores. Each stored fact is tested by the very next verdict. An extra verdict strobe shows one cycle after a non-exclusive or invalid operation.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_LOAD_EX  = 2'd1,
    OP_STORE    = 2'd2,
    OP_STORE_EX = 2'd3
  } opKind_t;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } monState_t;

  localparam int SIZE_W = 3;
  localparam logic [SIZE_W-1:0] SZ_NONE = 3'd0;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // record region and size
    logic clear;    // forget size
  } dpCtl_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IGNORE_BITS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [SIZE_W-1:0] opSize,
  output logic              tagHit,
  output logic              sizeHit
);

  localparam logic [ADDR_W-1:0] ADDR_MASK = {ADDR_W{1'b1}} << IGNORE_BITS;

  logic [ADDR_W-1:0] maskedAddr;
  logic [ADDR_W-1:0] tagReg;
  logic [SIZE_W-1:0] sizeReg;

  assign maskedAddr = opAddr & ADDR_MASK;
  assign tagHit     = (maskedAddr == tagReg);
  assign sizeHit    = (opSize == sizeReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagReg  <= '0;
      sizeReg <= SZ_NONE;
    end else if (ctl.capture) begin
      tagReg  <= maskedAddr;
      sizeReg <= opSize;
    end else if (ctl.clear) begin
      sizeReg <= SZ_NONE;
    end
  end

  // R10: a capture records the new region and size
  a_r10_capture_region: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (tagReg == ($past(opAddr) & ADDR_MASK)) && (sizeReg == $past(opSize)));

  // R6: a clear leaves size none
  a_r6_clear_size_none: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clear && !ctl.capture) |=> (sizeReg == SZ_NONE));

  // R3: low bits never held in the tag
  a_r3_tag_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (tagReg & ~ADDR_MASK) == '0);

endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opKind,
  input  logic       tagHit,
  input  logic       sizeHit,
  output dpCtl_t     ctl,
  output logic       resultValid,
  output logic       localPass,
  output logic       statusCode
);

  monState_t state, stateNext;
  logic isLoadEx, isStore, isStoreEx, passNow;

  assign isLoadEx  = opValid && (opKind == OP_LOAD_EX);
  assign isStore   = opValid && (opKind == OP_STORE);
  assign isStoreEx = opValid && (opKind == OP_STORE_EX);
  assign passNow   = isStoreEx && (state == MON_EXCL) && tagHit && sizeHit;

  always_comb begin
    ctl.capture = isLoadEx;
    ctl.clear   = isStoreEx || (isStore && tagHit);
    stateNext   = state;
    if (ctl.capture)      stateNext = MON_EXCL;
    else if (ctl.clear)   stateNext = MON_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= MON_OPEN;
      resultValid <= 1'b0;
      localPass   <= 1'b0;
      statusCode  <= 1'b0;
    end else begin
      state       <= stateNext;
      resultValid <= isStoreEx;
      localPass   <= passNow;
      statusCode  <= isStoreEx && !passNow;
    end
  end

  // R9: verdict strobe only after an exclusive store
  a_r9_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(opValid && (opKind == OP_STORE_EX)));

  // R9: no flags without a strobe
  a_r9_quiet_flags: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!localPass && !statusCode));

  // R6: any exclusive store leaves the monitor open
  a_r6_store_ex_opens: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opKind == OP_STORE_EX)) |=> (state == MON_OPEN));

  // R2: a pass needs a held reservation
  a_r2_pass_needs_excl: assert property (@(posedge clk) disable iff (!rstN)
    localPass |-> $past(state == MON_EXCL));

  // R8: a plain load keeps the state
  a_r8_load_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opKind == OP_LOAD)) |=> $stable(state));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IGNORE_BITS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [SIZE_W-1:0] opSize,
  output logic              resultValid,
  output logic              localPass,
  output logic              statusCode
);

  dpCtl_t ctl;
  logic   tagHit, sizeHit;

  resv_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opKind      (opKind),
    .tagHit      (tagHit),
    .sizeHit     (sizeHit),
    .ctl         (ctl),
    .resultValid (resultValid),
    .localPass   (localPass),
    .statusCode  (statusCode)
  );

  resv_datapath #(
    .ADDR_W      (ADDR_W),
    .IGNORE_BITS (IGNORE_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opAddr  (opAddr),
    .opSize  (opSize),
    .tagHit  (tagHit),
    .sizeHit (sizeHit)
  );

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opKind = 2'd0;
  logic [31:0] opAddr = 32'd0;
  logic [2:0]  opSize = 3'd0;
  logic        resultValid, localPass, statusCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  resv_monitor u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .opSize(opSize),
    .resultValid(resultValid), .localPass(localPass), .statusCode(statusCode)
  );

  // vector: req[4], kind[2], addr[32], size[3], expValid[1], expStatus[1]
  localparam int NV = 24;
  localparam logic [42:0] VEC [NV] = '{
    {4'd1,  2'd3, 32'h0000_1000, 3'd4, 1'b1, 1'b1}, // R1 open after reset
    {4'd2,  2'd1, 32'h0000_1000, 3'd4, 1'b0, 1'b0},
    {4'd2,  2'd3, 32'h0000_1000, 3'd4, 1'b1, 1'b0}, // R2 pass
    {4'd6,  2'd3, 32'h0000_1000, 3'd4, 1'b1, 1'b1}, // R6 cleared by pass
    {4'd3,  2'd1, 32'h0000_2004, 3'd2, 1'b0, 1'b0},
    {4'd3,  2'd3, 32'h0000_27FE, 3'd2, 1'b1, 1'b0}, // R3 low bits ignored
    {4'd4,  2'd1, 32'h0000_2000, 3'd2, 1'b0, 1'b0},
    {4'd4,  2'd3, 32'h0000_2800, 3'd2, 1'b1, 1'b1}, // R4 bit 11 differs
    {4'd5,  2'd1, 32'h0000_3000, 3'd1, 1'b0, 1'b0},
    {4'd5,  2'd3, 32'h0000_3000, 3'd2, 1'b1, 1'b1}, // R5 size mismatch
    {4'd6,  2'd3, 32'h0000_3000, 3'd1, 1'b1, 1'b1}, // R6 cleared by fail
    {4'd8,  2'd1, 32'h0000_4000, 3'd4, 1'b0, 1'b0},
    {4'd8,  2'd0, 32'h0000_4000, 3'd0, 1'b0, 1'b0}, // R8 plain load
    {4'd7,  2'd2, 32'h0000_5000, 3'd0, 1'b0, 1'b0}, // R7 store elsewhere
    {4'd7,  2'd3, 32'h0000_4010, 3'd4, 1'b1, 1'b0}, // R7/R8 reservation kept
    {4'd7,  2'd1, 32'h0000_4000, 3'd4, 1'b0, 1'b0},
    {4'd7,  2'd2, 32'h0000_47FF, 3'd0, 1'b0, 1'b0}, // R7 store in region
    {4'd7,  2'd3, 32'h0000_4000, 3'd4, 1'b1, 1'b1}, // R7 cleared
    {4'd10, 2'd1, 32'h0000_6000, 3'd4, 1'b0, 1'b0},
    {4'd10, 2'd1, 32'h0000_7000, 3'd1, 1'b0, 1'b0},
    {4'd10, 2'd3, 32'h0000_6000, 3'd4, 1'b1, 1'b1}, // R10 old region gone
    {4'd10, 2'd1, 32'h0000_6000, 3'd4, 1'b0, 1'b0},
    {4'd10, 2'd1, 32'h0000_7000, 3'd1, 1'b0, 1'b0},
    {4'd10, 2'd3, 32'h0000_7000, 3'd1, 1'b1, 1'b0}  // R10 new region passes
  };

  task automatic check(input int req, input logic expV, input logic expS);
    logic expP;
    expP = expV && !expS;
    checks++;
    if (resultValid !== expV || statusCode !== expS || localPass !== expP) begin
      errors++;
      $display("FAIL R%0d: valid/pass/status = %b/%b/%b expected %b/%b/%b",
               req, resultValid, localPass, statusCode, expV, expP, expS);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k,
                       input logic [31:0] a, input logic [2:0] s);
    opValid = v; opKind = k; opAddr = a; opSize = s;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(1, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset tag 0 / size none must not match
    drive(1'b1, 2'd3, 32'h0, 3'd0);
    check(1, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][38:37], VEC[i][36:5], VEC[i][4:2]);
      check(int'(VEC[i][42:39]), VEC[i][1], VEC[i][0]);
    end

    // R9: invalid cycle ignored, even with store-exclusive kind
    drive(1'b1, 2'd1, 32'h0000_8000, 3'd2);
    drive(1'b0, 2'd3, 32'h0000_8000, 3'd2);
    check(9, 1'b0, 1'b0);
    drive(1'b1, 2'd3, 32'h0000_8000, 3'd2);
    check(9, 1'b1, 1'b0);
    // R9: strobe lasts one cycle
    @(negedge clk);
    check(9, 1'b0, 1'b0);

    // R1: reset drops a held reservation
    drive(1'b1, 2'd1, 32'h0000_9000, 3'd4);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 2'd3, 32'h0000_9000, 3'd4);
    check(1, 1'b1, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule